// File: doc/BRIEF.md
# Processor Power-Down and Wake Controller

This controller sits beside a small processor core and handles two low-power states. The core's decode stage raises a one-cycle request when it meets a halt or a sleep instruction. The controller then stops the clocks that state needs. A light halt stops only the core clock. A deep sleep stops both the core clock and the peripheral clock. The controller runs on a free-running clock and drives two clock-enable outputs, which the gating cells of the two domains use.

Four sources end a power-down state: an asynchronous reset, a maskable interrupt request, a non-maskable interrupt and a debug exception. A masked interrupt still wakes the core. The mask settings only decide what the core does next. On wake the controller gives a one-cycle verdict. It either tells the core to enter a trap handler, with the return address being the instruction after the power-down instruction, or it tells the core to continue straight at that instruction. Leaving deep sleep first waits out a stabilization interval before either clock is enabled again.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, and immediately on its assertion, `pd_state` is 2'b00 (run), both clock enables are 1, and `resume_trap` and `resume_next` are 0.
- R2: In run, a `halt_req` seen at a rising edge moves `pd_state` to 2'b01 (halt) at that edge. In halt `core_clk_en` is 0 and `periph_clk_en` is 1.
- R3: In run, a `sleep_req` seen at a rising edge moves `pd_state` to 2'b10 (sleep) at that edge, with both enables 0. If `sleep_req` and `halt_req` arrive together, sleep wins.
- R4: `irq_req`, `nmi_req` and `dbg_req` pass through a two-flop synchronizer. A wake source raised just after rising edge k is acted on at edge k+3, and never earlier.
- R5: A wake in halt returns `pd_state` to run at that edge, and `core_clk_en` comes back in the same cycle.
- R6: A wake in sleep moves `pd_state` to 2'b11 (waking) for STAB_CYCLES cycles with both enables still 0. After that it goes to run with both enables 1.
- R7: A maskable interrupt wakes the block even when `irq_global_en` or `irq_line_en` is 0. If either is 0 and no other source is active, the wake ends with a one-cycle `resume_next` pulse and `resume_trap` stays 0.
- R8: The wake ends with a one-cycle `resume_trap` pulse, and no `resume_next`, if `nmi_req` or `dbg_req` is active, whatever the enables are. It does the same if `irq_req` is active with both enables at 1. A pulse occurs only on the cycle of entering run, and the two pulses never occur together.
- R9: Both clock enables change only on a falling edge of `clk`. They hold their value from each rising edge to the next falling edge.
- R10: `halt_req` and `sleep_req` have no effect outside run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, highest-priority wake |
| halt_req | input | 1 | One-cycle light power-down request from decode |
| sleep_req | input | 1 | One-cycle deep power-down request from decode |
| irq_req | input | 1 | Maskable interrupt request (asynchronous) |
| nmi_req | input | 1 | Non-maskable interrupt (asynchronous) |
| dbg_req | input | 1 | Debug exception (asynchronous) |
| irq_global_en | input | 1 | Core global interrupt-enable flag |
| irq_line_en | input | 1 | Interrupt controller enable for the requesting line |
| core_clk_en | output | 1 | Core clock-domain enable |
| periph_clk_en | output | 1 | Peripheral clock-domain enable |
| resume_trap | output | 1 | One-cycle pulse: enter handler, return after power-down instruction |
| resume_next | output | 1 | One-cycle pulse: continue at instruction after power-down instruction |
| pd_state | output | 2 | 00 run, 01 halt, 10 sleep, 11 waking |

## Verification
The case of interest is a power-down request that arrives while a wake source is already on its way. The bench raises `halt_req` together with `nmi_req`, and also with `irq_req`. The block must still enter halt on that edge. Once the synchronizer catches up, it must leave halt with the correct trap-or-continue verdict. A second collision drives `halt_req` and `sleep_req` together, and the result must be sleep. A third sends a sleep request while the block is already halted, and halt must hold with the peripheral clock still running.

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl #(
  parameter int STAB_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       sleep_req,
  input  logic       irq_req,
  input  logic       nmi_req,
  input  logic       dbg_req,
  input  logic       irq_global_en,
  input  logic       irq_line_en,
  output logic       core_clk_en,
  output logic       periph_clk_en,
  output logic       resume_trap,
  output logic       resume_next,
  output logic [1:0] pd_state
);
  localparam int CW = $clog2(STAB_CYCLES + 1);
  localparam logic [1:0] ST_RUN   = 2'b00;
  localparam logic [1:0] ST_HALT  = 2'b01;
  localparam logic [1:0] ST_SLEEP = 2'b10;
  localparam logic [1:0] ST_WAKE  = 2'b11;

  logic [2:0]    sync1, sync2;
  logic [1:0]    state;
  logic [CW-1:0] cnt;
  logic          trap_hold;

  wire wake     = |sync2;
  wire trap_now = sync2[2] | sync2[1] | (sync2[0] & irq_global_en & irq_line_en);

  assign pd_state = state;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {dbg_req, nmi_req, irq_req};
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state       <= ST_RUN;
      cnt         <= '0;
      trap_hold   <= 1'b0;
      resume_trap <= 1'b0;
      resume_next <= 1'b0;
    end else begin
      resume_trap <= 1'b0;
      resume_next <= 1'b0;
      case (state)
        ST_RUN:
          if (sleep_req)     state <= ST_SLEEP;
          else if (halt_req) state <= ST_HALT;
        ST_HALT:
          if (wake) begin
            state       <= ST_RUN;
            resume_trap <= trap_now;
            resume_next <= !trap_now;
          end
        ST_SLEEP:
          if (wake) begin
            state     <= ST_WAKE;
            cnt       <= CW'(STAB_CYCLES - 1);
            trap_hold <= trap_now;
          end
        default:
          if (cnt == '0) begin
            state       <= ST_RUN;
            resume_trap <= trap_hold;
            resume_next <= !trap_hold;
          end else begin
            cnt <= cnt - 1'b1;
          end
      endcase
    end

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      core_clk_en   <= 1'b1;
      periph_clk_en <= 1'b1;
    end else begin
      core_clk_en   <= (state == ST_RUN);
      periph_clk_en <= (state == ST_RUN) || (state == ST_HALT);
    end
endmodule

// File: rtl/pwr_wake_ctrl_chk.sv
module pwr_wake_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic       sleep_req,
  input logic       core_clk_en,
  input logic       periph_clk_en,
  input logic       resume_trap,
  input logic       resume_next,
  input logic [1:0] pd_state
);
  // R2
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == 2'b00 && halt_req && !sleep_req) |=> pd_state == 2'b01);

  // R3
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == 2'b00 && sleep_req) |=> pd_state == 2'b10);

  // R2
  halt_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_state == 2'b01 |-> (!core_clk_en && periph_clk_en));

  // R6
  deep_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_state[1] |-> (!core_clk_en && !periph_clk_en));

  // R5
  run_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_state == 2'b00 |-> (core_clk_en && periph_clk_en));

  // R6
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_state == 2'b10 |=> pd_state != 2'b00);

  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(resume_trap && resume_next));

  // R8
  verdict_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_trap || resume_next) |-> (pd_state == 2'b00 && $past(pd_state) != 2'b00));

  // R9
  always @(core_clk_en or periph_clk_en)
    if (rst_n === 1'b1)
      enable_low_phase_chk: assert (clk == 1'b0);
endmodule

bind pwr_wake_ctrl pwr_wake_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
  .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
  .resume_trap(resume_trap), .resume_next(resume_next), .pd_state(pd_state)
);

// File: tb/tb_pwr_wake_ctrl.sv
module tb_pwr_wake_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, sleep_req = 0, irq_req = 0, nmi_req = 0, dbg_req = 0;
  logic irq_global_en = 1, irq_line_en = 1;
  logic core_clk_en, periph_clk_en, resume_trap, resume_next;
  logic [1:0] pd_state;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  pwr_wake_ctrl dut (.*);

  // {halt,sleep,irq,nmi,dbg,gen,len} {state} {core,periph,trap,next} {req}
  localparam int ROWS = 27;
  localparam logic [16:0] TBL [ROWS] = '{
    {7'b1000011, 2'b01, 4'b0100, 4'd2},  // R2 enter halt
    {7'b0000011, 2'b01, 4'b0100, 4'd2},
    {7'b0100011, 2'b01, 4'b0100, 4'd10}, // R10 sleep ignored in halt
    {7'b0010001, 2'b01, 4'b0100, 4'd4},  // R4 masked irq, sync stage 1
    {7'b0010001, 2'b01, 4'b0100, 4'd4},  // R4 sync stage 2
    {7'b0010001, 2'b00, 4'b1101, 4'd7},  // R7 masked irq wakes, continue
    {7'b0000011, 2'b00, 4'b1100, 4'd5},
    {7'b0000011, 2'b00, 4'b1100, 4'd5},
    {7'b1001011, 2'b01, 4'b0100, 4'd2},  // halt with nmi in flight
    {7'b0001011, 2'b01, 4'b0100, 4'd4},
    {7'b0001001, 2'b00, 4'b1110, 4'd8},  // R8 nmi traps despite mask
    {7'b0000011, 2'b00, 4'b1100, 4'd5},
    {7'b0000011, 2'b00, 4'b1100, 4'd5},
    {7'b0000011, 2'b00, 4'b1100, 4'd5},
    {7'b1010011, 2'b01, 4'b0100, 4'd2},  // halt with enabled irq
    {7'b0010011, 2'b01, 4'b0100, 4'd4},
    {7'b0010011, 2'b00, 4'b1110, 4'd8},  // R8 enabled irq traps
    {7'b0000011, 2'b00, 4'b1100, 4'd8},
    {7'b0000011, 2'b00, 4'b1100, 4'd5},
    {7'b0000011, 2'b00, 4'b1100, 4'd5},
    {7'b1010010, 2'b01, 4'b0100, 4'd2},  // line enable clear
    {7'b0010010, 2'b01, 4'b0100, 4'd4},
    {7'b0010010, 2'b00, 4'b1101, 4'd7},  // R7 continue
    {7'b0000011, 2'b00, 4'b1100, 4'd5},
    {7'b0000011, 2'b00, 4'b1100, 4'd5},
    {7'b0000011, 2'b00, 4'b1100, 4'd5},
    {7'b1100011, 2'b10, 4'b0000, 4'd3}   // R3 sleep beats halt
  };

  task automatic step();
    @(posedge clk); #7;
  endtask

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s {state,core,periph,trap,next} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] obs();
    return {pd_state, core_clk_en, periph_clk_en, resume_trap, resume_next};
  endfunction

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(posedge clk); #7;
    chk("R1 in reset", obs(), 6'b00_1100);
    rst_n = 1'b1;
    step();
    chk("R1 after release", obs(), 6'b00_1100);

    for (int i = 0; i < ROWS; i++) begin
      {halt_req, sleep_req, irq_req, nmi_req, dbg_req, irq_global_en, irq_line_en} = TBL[i][16:10];
      step();
      chk($sformatf("R%0d row %0d", TBL[i][3:0], i), obs(), TBL[i][9:4]);
    end

    // R6 deep wake by debug exception, stabilization window
    {halt_req, sleep_req, irq_req, nmi_req, dbg_req} = 5'b00001;
    step(); step();
    chk("R4 sleep held during sync", obs(), 6'b10_0000);
    step();
    chk("R6 waking entered", obs(), 6'b11_0000);
    for (int k = 4; k < 19; k++) step();
    chk("R6 still waking at last count", obs(), 6'b11_0000);
    step();
    chk("R6 run after window, R8 debug traps", obs(), 6'b00_1110);
    dbg_req = 1'b0;
    step();
    chk("R8 trap is one cycle", obs(), 6'b00_1100);
    step(); step();

    // R9 enable changes at falling edge only
    halt_req = 1'b1;
    @(posedge clk); #3;
    halt_req = 1'b0;
    chk("R9 enable held before falling edge", obs(), 6'b01_1100);
    #4;
    chk("R9 enable dropped after falling edge", obs(), 6'b01_0100);

    // R10 halt request while halted is ignored
    halt_req = 1'b1;
    step();
    halt_req = 1'b0;
    chk("R10 halt in halt", obs(), 6'b01_0100);

    // R1 reset wakes at once
    #1 rst_n = 1'b0;
    #1;
    chk("R1 reset wake", obs(), 6'b00_1100);
    step();
    rst_n = 1'b1;
    step();
    chk("R1 run after reset", obs(), 6'b00_1100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule